// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block holds the transmit and receive queues of an SPI controller. It also derives the status word and the maskable interrupt set that software uses to pace transfers. Words written by the bus side enter the transmit queue and leave towards the serial engine. Words captured by the serial engine enter the receive queue and are read out by the bus side. Both queue fill levels are visible at all times.

A controller-enable input gates the whole datapath. While it is low, both queues are held empty and every push and pop strobe is ignored. The receive-threshold register can be written only in that state. Five interrupt sources are produced:
- Two follow the queue levels directly: transmit queue empty, and receive level above the threshold.
- Three are sticky error flags: transmit overflow, receive overflow and receive underflow. They stay set until a write to the clear port removes them.

Each source is masked individually, and the interrupt output is the OR of the masked sources.

The serial transmit side is a valid/ready stream. `ser_tx_valid` is high whenever the unit is enabled and the transmit queue holds a word, and `ser_tx_data` holds that word. A word is consumed on a cycle with `ser_tx_valid && ser_tx_ready`. The data must stay at the head until then. The serial receive side and both bus-side strobes have no back-pressure: a word or request that cannot be served is dropped and flagged.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: Words written with `bus_tx_wr` leave on `ser_tx_data` in write order. `ser_tx_valid` equals enable AND (transmit level > 0). A word is removed on a cycle with `ser_tx_valid && ser_tx_ready`.
- R2: Words pushed with `ser_rx_valid` appear on `bus_rx_data` in arrival order. A `bus_rx_rd` on a non-empty queue removes the head word.
- R3: `tx_level` and `rx_level` give the number of words held, from 0 to DEPTH. Each is updated on the clock edge that accepts a push or a pop.
- R4: `status` bit 0 = `engine_busy`, bit 1 = transmit level equals DEPTH, bit 2 = transmit level is 0, bit 3 = receive level is 0, bit 4 = receive level equals DEPTH.
- R5: A transmit push while the transmit level is DEPTH is dropped and sets sticky `irq_raw` bit 1. A receive push while the receive level is DEPTH is dropped and sets sticky `irq_raw` bit 3. In both cases a pop in the same cycle does not make room.
- R6: A `bus_rx_rd` while the receive level is 0 is dropped and sets sticky `irq_raw` bit 2.
- R7: `irq_raw` bit 0 is 1 exactly when the transmit level is 0. `irq_raw` bit 4 is 1 exactly when the receive level is greater than `rx_thresh`, so it first rises at threshold+1 words.
- R8: A `thresh_wr` is taken into `rx_thresh` only on a cycle with `enable` low. It is ignored while enabled.
- R9: A `clr_wr` cycle acts on the sticky flags as follows: `clr_wdata` bit 0 clears all of them, bit 1 clears receive underflow, bit 2 clears receive overflow and bit 3 clears transmit overflow. If a flag is set and cleared in the same cycle, it ends up set.
- R10: `mask_wr` loads `irq_mask`. `irq_masked` = `irq_raw` AND `irq_mask`. `irq` is the OR of `irq_masked`.
- R11: While `enable` is low, both levels become 0 at the next edge and every push or pop strobe is ignored. This raises no error flag and leaves the sticky flags as they are.
- R12: After reset, both levels, `rx_thresh`, `irq_mask` and all sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low flushes both queues |
| engine_busy | input | 1 | Busy indication from the serial engine |
| bus_tx_wr | input | 1 | Bus-side transmit push strobe |
| bus_tx_data | input | WIDTH | Transmit word to push |
| ser_tx_valid | output | 1 | Transmit head word available |
| ser_tx_ready | input | 1 | Serial engine takes the head word |
| ser_tx_data | output | WIDTH | Transmit head word |
| ser_rx_valid | input | 1 | Serial-side receive push strobe |
| ser_rx_data | input | WIDTH | Received word to push |
| bus_rx_rd | input | 1 | Bus-side receive pop strobe |
| bus_rx_data | output | WIDTH | Receive head word |
| thresh_wr | input | 1 | Threshold write strobe |
| thresh_wdata | input | LVL_W | Threshold value to write |
| rx_thresh | output | LVL_W | Current receive threshold |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 5 | Mask value to write |
| irq_mask | output | 5 | Current interrupt mask |
| clr_wr | input | 1 | Clear write strobe |
| clr_wdata | input | 4 | Clear bits |
| tx_level | output | LVL_W | Transmit queue level |
| rx_level | output | LVL_W | Receive queue level |
| status | output | 5 | Status word |
| irq_raw | output | 5 | Unmasked interrupt sources |
| irq_masked | output | 5 | Masked interrupt sources |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that all inputs are synchronous to `clk` and that `ser_tx_data` is only meaningful while `ser_tx_valid` is high. They also assume nothing about the rates of strobes from either side: pushes into a full queue and reads from an empty one are legal and are expected to be flagged. The stimulus therefore drives every strobe independently at biased rates. One phase is push-heavy and fills both queues past full. Another is pop-heavy and drains them past empty. A mixed phase adds random mask and clear writes. A phase that toggles `enable` exercises flushing and threshold writes, including attempts made while enabled.

// File: rtl/spi_fsi_pkg.sv
package spi_fsi_pkg;
  localparam int IRQ_N   = 5;
  // interrupt source positions
  localparam int IRQ_TXE = 0;
  localparam int IRQ_TXO = 1;
  localparam int IRQ_RXU = 2;
  localparam int IRQ_RXO = 3;
  localparam int IRQ_RXF = 4;
  // status word positions
  localparam int ST_BUSY = 0;
  localparam int ST_TXF  = 1;
  localparam int ST_TXE  = 2;
  localparam int ST_RXE  = 3;
  localparam int ST_RXF  = 4;
  // clear port positions
  localparam int CLR_N   = 4;
  localparam int CLR_ALL = 0;
  localparam int CLR_RXU = 1;
  localparam int CLR_RXO = 2;
  localparam int CLR_TXO = 3;
endpackage

// File: rtl/fsi_fifo.sv
module fsi_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push_req,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic [WIDTH-1:0] head,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             push_drop,
  output logic             pop_drop
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  assign full      = (level == LVL_W'(DEPTH));
  assign empty     = (level == '0);
  assign push_ok   = push_req && !full  && !flush;
  assign pop_ok    = pop_req  && !empty && !flush;
  assign push_drop = push_req &&  full  && !flush;
  assign pop_drop  = pop_req  &&  empty && !flush;
  assign head      = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/fsi_irq.sv
module fsi_irq
  import spi_fsi_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  rx_thresh,
  input  logic              tx_ovf_set,
  input  logic              rx_ovf_set,
  input  logic              rx_udf_set,
  input  logic              clr_wr,
  input  logic [CLR_N-1:0]  clr_wdata,
  input  logic              mask_wr,
  input  logic [IRQ_N-1:0]  mask_wdata,
  output logic [IRQ_N-1:0]  raw,
  output logic [IRQ_N-1:0]  mask,
  output logic [IRQ_N-1:0]  masked,
  output logic              irq
);
  logic txo_q, rxo_q, rxu_q;
  logic clr_txo, clr_rxo, clr_rxu;

  assign clr_txo = clr_wr && (clr_wdata[CLR_ALL] || clr_wdata[CLR_TXO]);
  assign clr_rxo = clr_wr && (clr_wdata[CLR_ALL] || clr_wdata[CLR_RXO]);
  assign clr_rxu = clr_wr && (clr_wdata[CLR_ALL] || clr_wdata[CLR_RXU]);

  // setting has priority over clearing in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txo_q <= 1'b0;
      rxo_q <= 1'b0;
      rxu_q <= 1'b0;
      mask  <= '0;
    end else begin
      txo_q <= tx_ovf_set || (txo_q && !clr_txo);
      rxo_q <= rx_ovf_set || (rxo_q && !clr_rxo);
      rxu_q <= rx_udf_set || (rxu_q && !clr_rxu);
      if (mask_wr) mask <= mask_wdata;
    end
  end

  always_comb begin
    raw          = '0;
    raw[IRQ_TXE] = (tx_level == '0);
    raw[IRQ_TXO] = txo_q;
    raw[IRQ_RXU] = rxu_q;
    raw[IRQ_RXO] = rxo_q;
    raw[IRQ_RXF] = (rx_level > rx_thresh);
  end

  assign masked = raw & mask;
  assign irq    = |masked;
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_fsi_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             engine_busy,
  input  logic             bus_tx_wr,
  input  logic [WIDTH-1:0] bus_tx_data,
  output logic             ser_tx_valid,
  input  logic             ser_tx_ready,
  output logic [WIDTH-1:0] ser_tx_data,
  input  logic             ser_rx_valid,
  input  logic [WIDTH-1:0] ser_rx_data,
  input  logic             bus_rx_rd,
  output logic [WIDTH-1:0] bus_rx_data,
  input  logic             thresh_wr,
  input  logic [LVL_W-1:0] thresh_wdata,
  output logic [LVL_W-1:0] rx_thresh,
  input  logic             mask_wr,
  input  logic [4:0]       mask_wdata,
  output logic [4:0]       irq_mask,
  input  logic             clr_wr,
  input  logic [3:0]       clr_wdata,
  output logic [LVL_W-1:0] tx_level,
  output logic [LVL_W-1:0] rx_level,
  output logic [4:0]       status,
  output logic [4:0]       irq_raw,
  output logic [4:0]       irq_masked,
  output logic             irq
);
  logic flush;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_push_drop, tx_pop_drop, rx_push_drop, rx_pop_drop;

  assign flush        = !enable;
  assign ser_tx_valid = enable && !tx_empty;

  fsi_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push_req  (bus_tx_wr),
    .push_data (bus_tx_data),
    .pop_req   (ser_tx_ready),
    .head      (ser_tx_data),
    .level     (tx_level),
    .full      (tx_full),
    .empty     (tx_empty),
    .push_drop (tx_push_drop),
    .pop_drop  (tx_pop_drop)
  );

  fsi_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push_req  (ser_rx_valid),
    .push_data (ser_rx_data),
    .pop_req   (bus_rx_rd),
    .head      (bus_rx_data),
    .level     (rx_level),
    .full      (rx_full),
    .empty     (rx_empty),
    .push_drop (rx_push_drop),
    .pop_drop  (rx_pop_drop)
  );

  // threshold is only writable while the controller is disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rx_thresh <= '0;
    else if (thresh_wr && flush) rx_thresh <= thresh_wdata;
  end

  fsi_irq #(.LVL_W(LVL_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .rx_thresh  (rx_thresh),
    .tx_ovf_set (tx_push_drop),
    .rx_ovf_set (rx_push_drop),
    .rx_udf_set (rx_pop_drop),
    .clr_wr     (clr_wr),
    .clr_wdata  (clr_wdata),
    .mask_wr    (mask_wr),
    .mask_wdata (mask_wdata),
    .raw        (irq_raw),
    .mask       (irq_mask),
    .masked     (irq_masked),
    .irq        (irq)
  );

  always_comb begin
    status          = '0;
    status[ST_BUSY] = engine_busy;
    status[ST_TXF]  = tx_full;
    status[ST_TXE]  = tx_empty;
    status[ST_RXE]  = rx_empty;
    status[ST_RXF]  = rx_full;
  end

  logic unused_ok;
  assign unused_ok = tx_pop_drop;
endmodule

// File: rtl/fsi_chk.sv
module fsi_chk #(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             bus_tx_wr,
  input logic             ser_tx_valid,
  input logic             ser_tx_ready,
  input logic             bus_rx_rd,
  input logic [LVL_W-1:0] rx_thresh,
  input logic [4:0]       irq_mask,
  input logic             clr_wr,
  input logic [3:0]       clr_wdata,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic [4:0]       status,
  input logic [4:0]       irq_raw,
  input logic             irq
);
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

  assert_full_not_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[1] && status[2]) && !(status[4] && status[3]));

  assert_tx_overflow_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tx_level == LVL_W'(DEPTH) && bus_tx_wr && !(ser_tx_valid && ser_tx_ready))
    |=> (tx_level == LVL_W'(DEPTH)) && irq_raw[1]);

  assert_rx_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rx_level == '0 && bus_rx_rd) |=> irq_raw[2]);

  assert_thresh_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(rx_thresh));

  assert_txo_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raw[1] && !(clr_wr && (clr_wdata[0] || clr_wdata[3]))) |=> irq_raw[1]);

  assert_irq_from_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_raw & irq_mask) != 5'd0) |-> irq);

  assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (tx_level == '0) && (rx_level == '0));
endmodule

bind spi_fifo_irq_unit fsi_chk #(.DEPTH(DEPTH)) u_fsi_chk (.*);

// File: tb/tb_spi_fifo_irq_unit.sv
module tb_spi_fifo_irq_unit;
  localparam int DEPTH = 32;
  localparam int WIDTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0, engine_busy = 1'b0;
  logic             bus_tx_wr = 1'b0, ser_tx_ready = 1'b0, ser_rx_valid = 1'b0, bus_rx_rd = 1'b0;
  logic [WIDTH-1:0] bus_tx_data = '0, ser_rx_data = '0;
  logic             thresh_wr = 1'b0, mask_wr = 1'b0, clr_wr = 1'b0;
  logic [LVL_W-1:0] thresh_wdata = '0;
  logic [4:0]       mask_wdata = '0;
  logic [3:0]       clr_wdata = '0;
  logic             ser_tx_valid, irq;
  logic [WIDTH-1:0] ser_tx_data, bus_rx_data;
  logic [LVL_W-1:0] rx_thresh, tx_level, rx_level;
  logic [4:0]       irq_mask, status, irq_raw, irq_masked;

  spi_fifo_irq_unit #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int txq[$], rxq[$];
  bit m_txo, m_rxo, m_rxu;
  int m_mask, m_th;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] m_raw();
    logic [4:0] r;
    r[0] = (txq.size() == 0);
    r[1] = m_txo;
    r[2] = m_rxu;
    r[3] = m_rxo;
    r[4] = (rxq.size() > m_th);
    return r;
  endfunction

  task automatic compare_all();
    logic [4:0] st;
    logic [4:0] r;
    r = m_raw();
    st = {rxq.size() == DEPTH, rxq.size() == 0, txq.size() == 0, txq.size() == DEPTH, engine_busy};
    chk("R1 ser_tx_valid", ser_tx_valid, enable && txq.size() > 0);
    if (txq.size() > 0) chk("R1 ser_tx_data", ser_tx_data, txq[0]);
    if (rxq.size() > 0) chk("R2 bus_rx_data", bus_rx_data, rxq[0]);
    chk("R3 tx_level", tx_level, txq.size());
    chk("R3 rx_level", rx_level, rxq.size());
    chk("R4 status", status, st);
    chk("R7 raw tx empty", irq_raw[0], r[0]);
    chk("R5 R9 raw tx overflow", irq_raw[1], r[1]);
    chk("R6 R9 raw rx underflow", irq_raw[2], r[2]);
    chk("R5 R9 raw rx overflow", irq_raw[3], r[3]);
    chk("R7 raw rx above threshold", irq_raw[4], r[4]);
    chk("R8 rx_thresh", rx_thresh, m_th);
    chk("R10 irq_mask", irq_mask, m_mask);
    chk("R10 irq_masked", irq_masked, r & 5'(m_mask));
    chk("R10 irq", irq, |(r & 5'(m_mask)));
  endtask

  // reference model: next state from current state and held inputs
  task automatic model_step();
    bit tfull, rempty, rfull, txo, rxo, rxu;
    tfull = (txq.size() == DEPTH);
    rempty = (rxq.size() == 0);
    rfull = (rxq.size() == DEPTH);
    txo = 0; rxo = 0; rxu = 0;
    if (!enable) begin
      txq.delete();
      rxq.delete();
    end else begin
      if (ser_tx_ready && txq.size() > 0) void'(txq.pop_front());
      if (bus_tx_wr) begin
        if (tfull) txo = 1; else txq.push_back(int'(bus_tx_data));
      end
      if (bus_rx_rd) begin
        if (rempty) rxu = 1; else void'(rxq.pop_front());
      end
      if (ser_rx_valid) begin
        if (rfull) rxo = 1; else rxq.push_back(int'(ser_rx_data));
      end
    end
    if (clr_wr) begin
      if (clr_wdata[0] || clr_wdata[3]) m_txo = 0;
      if (clr_wdata[0] || clr_wdata[2]) m_rxo = 0;
      if (clr_wdata[0] || clr_wdata[1]) m_rxu = 0;
    end
    if (txo) m_txo = 1;
    if (rxo) m_rxo = 1;
    if (rxu) m_rxu = 1;
    if (mask_wr) m_mask = int'(mask_wdata);
    if (thresh_wr && !enable) m_th = int'(thresh_wdata);
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    bus_tx_wr = 0; ser_tx_ready = 0; ser_rx_valid = 0; bus_rx_rd = 0;
    thresh_wr = 0; mask_wr = 0; clr_wr = 0;
  endtask

  function automatic bit pct(int p);
    return $urandom_range(99) < p;
  endfunction

  task automatic run_phase(int cycles, int p_en, int p_txw, int p_txr, int p_rxv, int p_rxr, int p_ctl);
    for (int i = 0; i < cycles; i++) begin
      enable       = pct(p_en);
      engine_busy  = pct(50);
      bus_tx_wr    = pct(p_txw);
      bus_tx_data  = WIDTH'($urandom);
      ser_tx_ready = pct(p_txr);
      ser_rx_valid = pct(p_rxv);
      ser_rx_data  = WIDTH'($urandom);
      bus_rx_rd    = pct(p_rxr);
      thresh_wr    = pct(p_ctl);
      thresh_wdata = LVL_W'($urandom_range(DEPTH));
      mask_wr      = pct(p_ctl);
      mask_wdata   = 5'($urandom);
      clr_wr       = pct(p_ctl);
      clr_wdata    = 4'($urandom);
      tick();
    end
    idle_inputs();
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_txo = 0; m_rxo = 0; m_rxu = 0; m_mask = 0; m_th = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: reset state
    chk("R12 tx_level", tx_level, 0);
    chk("R12 rx_level", rx_level, 0);
    chk("R12 rx_thresh", rx_thresh, 0);
    chk("R12 irq_mask", irq_mask, 0);
    chk("R12 irq_raw", irq_raw, 5'b00001);

    // R8 and R7: threshold of 3, raw bit 4 rises at the fourth word
    thresh_wr = 1; thresh_wdata = LVL_W'(3); tick();
    thresh_wr = 0; enable = 1; tick();
    thresh_wr = 1; thresh_wdata = LVL_W'(9); tick();
    thresh_wr = 0;
    chk("R8 write while enabled ignored", rx_thresh, 3);
    for (int k = 0; k < 3; k++) begin
      ser_rx_valid = 1; ser_rx_data = WIDTH'(k + 16'h100); tick();
    end
    ser_rx_valid = 0;
    chk("R7 three words at threshold 3", irq_raw[4], 0);
    ser_rx_valid = 1; ser_rx_data = 16'h1ff; tick();
    ser_rx_valid = 0;
    chk("R7 four words at threshold 3", irq_raw[4], 1);

    // R11: disable flushes and keeps sticky flags
    bus_rx_rd = 1; repeat (5) tick();
    bus_rx_rd = 0;
    chk("R6 underflow raised", irq_raw[2], 1);
    bus_tx_wr = 1; bus_tx_data = 16'h55; repeat (3) tick();
    bus_tx_wr = 0; enable = 0; tick();
    chk("R11 tx flushed", tx_level, 0);
    chk("R11 sticky kept", irq_raw[2], 1);
    bus_rx_rd = 1; bus_tx_wr = 1; tick();
    idle_inputs();
    chk("R11 strobes ignored", tx_level, 0);
    clr_wr = 1; clr_wdata = 4'b0010; tick();
    clr_wr = 0;
    chk("R9 clear underflow", irq_raw[2], 0);

    // random phases
    run_phase(400, 100, 90, 5, 90, 5, 0);   // fill and overflow
    run_phase(400, 100, 5, 90, 5, 90, 0);   // drain and underflow
    run_phase(800, 100, 50, 50, 50, 50, 10);// mixed with mask and clear
    run_phase(600, 85, 60, 40, 60, 40, 15); // enable toggling
    run_phase(400, 100, 70, 30, 70, 30, 10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule